// File: doc/BRIEF.md
# Partition Access Lock Gate

This block sits in front of a partitioned one-time-programmable store and decides, per partition, whether reads and writes may pass. From each partition's 64-bit digest, a software read-enable bit and the partition's kind (fixed by its index), it derives a read lock and a write lock. Each lock is held in a register as an 8-bit redundant boolean. Two separate register sets are kept: one guards the buffered partition path and one guards the direct access path. Each path's gate consults only its own set.

Each path takes requests on a valid/ready interface. An allowed request goes on to the storage side unchanged. There, `*_fwd_ready_i` back-pressures the requester, and the storage must present `*_fwd_rdata_i` combinationally in the handshake cycle. A blocked request is taken at once, whatever the storage side's ready is, and is never forwarded. Every accepted request, allowed or blocked, produces one response beat in the following cycle. The response has no ready signal, and the requester must always take it.

The lock decision fails safe. A lock field unlocks only when it holds exactly the unlocked pattern. Any other byte, including corrupted or glitched values, blocks the access.

Top module: `part_lock_gate`

## Requirements
- R1: Lock fields are 8 bits wide. 0x69 means unlocked and 0x96 means locked. Every lock field resets to 0x69, so right after reset with zero digests and all read enables at 1, every access is allowed.
- R2: A lock field holding any value other than 0x69 blocks the matching operation on that partition, even if the value is not 0x96.
- R3: For partitions 0 to 6, a write lock is set once either 32-bit half of the partition's 64-bit digest (bits 31:0 or bits 63:32) is nonzero. The lock takes effect from the first clock edge after the digest input changes.
- R4: Partitions 0, 1 and 2 are software-configurable. Each becomes read-locked while its `sw_rd_en_i` bit is 0.
- R5: Partition 3 (hardware configuration) is never read-locked. Its `sw_rd_en_i` bit has no effect, and only its write lock follows its digest.
- R6: Partitions 4, 5 and 6 (secrets) become both read-locked and write-locked once their digest is nonzero.
- R7: The last partition (index 7, life cycle) is never locked by this gate.
- R8: The buffered path (`bp_*`) is gated only by its own lock set, and the direct path (`da_*`) only by its own set. A corrupted field in one set does not block the other path.
- R9: A blocked request sees ready high in the same cycle and is not forwarded, so a write is dropped. In the next cycle it produces a response with error set and all-zero data.
- R10: An allowed request is forwarded with ready equal to the storage side's ready. In the cycle after the handshake it produces a response with error clear. The response data is the storage read data for a read and zero for a write.
- R11: A response beat is valid for exactly one cycle per accepted request, and never when no request was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| digest_i | input | NUM_PART*64 | Per-partition digests, partition i at bits [64i+63:64i] |
| sw_rd_en_i | input | NUM_PART | Software read-enable bits; 0 read-locks a software partition |
| bp_req_valid_i | input | 1 | Buffered path request valid |
| bp_req_ready_o | output | 1 | Buffered path request ready |
| bp_req_we_i | input | 1 | Buffered path request is a write |
| bp_req_part_i | input | PIDX_W | Buffered path target partition |
| bp_req_wdata_i | input | DATA_W | Buffered path write data |
| bp_fwd_valid_o | output | 1 | Buffered path forwarded request valid |
| bp_fwd_ready_i | input | 1 | Buffered path storage ready |
| bp_fwd_we_o | output | 1 | Buffered path forwarded write flag |
| bp_fwd_part_o | output | PIDX_W | Buffered path forwarded partition |
| bp_fwd_wdata_o | output | DATA_W | Buffered path forwarded write data |
| bp_fwd_rdata_i | input | DATA_W | Buffered path storage read data, valid in the handshake cycle |
| bp_rsp_valid_o | output | 1 | Buffered path response valid |
| bp_rsp_rdata_o | output | DATA_W | Buffered path response data |
| bp_rsp_err_o | output | 1 | Buffered path access error |
| da_req_valid_i | input | 1 | Direct path request valid |
| da_req_ready_o | output | 1 | Direct path request ready |
| da_req_we_i | input | 1 | Direct path request is a write |
| da_req_part_i | input | PIDX_W | Direct path target partition |
| da_req_wdata_i | input | DATA_W | Direct path write data |
| da_fwd_valid_o | output | 1 | Direct path forwarded request valid |
| da_fwd_ready_i | input | 1 | Direct path storage ready |
| da_fwd_we_o | output | 1 | Direct path forwarded write flag |
| da_fwd_part_o | output | PIDX_W | Direct path forwarded partition |
| da_fwd_wdata_o | output | DATA_W | Direct path forwarded write data |
| da_fwd_rdata_i | input | DATA_W | Direct path storage read data, valid in the handshake cycle |
| da_rsp_valid_o | output | 1 | Direct path response valid |
| da_rsp_rdata_o | output | DATA_W | Direct path response data |
| da_rsp_err_o | output | 1 | Direct path access error |

## Verification
On every cycle, the assertions check that nothing is forwarded unless the relevant raw lock byte equals the unlocked pattern, so the fail-safe gate holds even while lock fields are corrupted. They also check that each accepted request produces exactly one response in the next cycle, that error responses carry zero data, and that a stalled request occurs only when the storage side stalls. The mapping from digests, read-enable bits and partition kinds to locks can only be shown by the bench's scenarios. The same holds for the independence of the two lock sets and for recovery after a corrupted field is released. For these, the bench overrides individual lock registers with random non-boolean bytes and observes each path's behaviour at its ports.

// File: rtl/plg_pkg.sv
package plg_pkg;

  typedef logic [7:0] mubi8_t;

  localparam mubi8_t MUBI8_LOCKED   = 8'h96;
  localparam mubi8_t MUBI8_UNLOCKED = 8'h69;

  localparam int NUM_SW_PARTS = 3;
  localparam int HW_PART_IDX  = 3;

  typedef enum logic [1:0] {
    KIND_SW,
    KIND_HW,
    KIND_SECRET,
    KIND_LC
  } part_kind_e;

  // Partition kind is fixed by index; the last index is always life cycle.
  function automatic part_kind_e kind_of(int idx, int num_part);
    if (idx == num_part - 1) return KIND_LC;
    if (idx < NUM_SW_PARTS)  return KIND_SW;
    if (idx == HW_PART_IDX)  return KIND_HW;
    return KIND_SECRET;
  endfunction

  function automatic mubi8_t mubi8_encode(logic lock);
    return lock ? MUBI8_LOCKED : MUBI8_UNLOCKED;
  endfunction

  // Fail safe: only the exact unlocked pattern lets an access through.
  function automatic logic mubi8_blocks(mubi8_t v);
    return v != MUBI8_UNLOCKED;
  endfunction

endpackage

// File: rtl/lg_lock_derive.sv
module lg_lock_derive
  import plg_pkg::*;
#(
  parameter part_kind_e KIND     = KIND_SW,
  parameter int         DIGEST_W = 64
) (
  input  logic [DIGEST_W-1:0] digest_i,
  input  logic                rd_en_i,
  output logic                rd_lock_o,
  output logic                wr_lock_o
);

  localparam int HALF_W = DIGEST_W / 2;

  logic dig_nz;
  logic unused_inputs;

  assign dig_nz = (|digest_i[HALF_W-1:0]) | (|digest_i[DIGEST_W-1:HALF_W]);
  assign unused_inputs = dig_nz ^ rd_en_i;

  generate
    if (KIND == KIND_SW) begin : g_sw
      assign rd_lock_o = ~rd_en_i;
      assign wr_lock_o = dig_nz;
    end else if (KIND == KIND_HW) begin : g_hw
      assign rd_lock_o = 1'b0;
      assign wr_lock_o = dig_nz;
    end else if (KIND == KIND_SECRET) begin : g_secret
      assign rd_lock_o = dig_nz;
      assign wr_lock_o = dig_nz;
    end else begin : g_lc
      assign rd_lock_o = 1'b0;
      assign wr_lock_o = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/lg_lock_reg.sv
module lg_lock_reg
  import plg_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   rd_lock_i,
  input  logic   wr_lock_i,
  output mubi8_t rd_mubi_o,
  output mubi8_t wr_mubi_o
);

  mubi8_t rd_q;
  mubi8_t wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= MUBI8_UNLOCKED;
      wr_q <= MUBI8_UNLOCKED;
    end else begin
      rd_q <= mubi8_encode(rd_lock_i);
      wr_q <= mubi8_encode(wr_lock_i);
    end
  end

  assign rd_mubi_o = rd_q;
  assign wr_mubi_o = wr_q;

endmodule

// File: rtl/lg_path_gate.sv
module lg_path_gate #(
  parameter int NUM_PART = 8,
  parameter int DATA_W   = 32,
  localparam int PIDX_W  = $clog2(NUM_PART)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PART-1:0] rd_blk_i,
  input  logic [NUM_PART-1:0] wr_blk_i,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic                req_we_i,
  input  logic [PIDX_W-1:0]   req_part_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  output logic                fwd_valid_o,
  input  logic                fwd_ready_i,
  output logic                fwd_we_o,
  output logic [PIDX_W-1:0]   fwd_part_o,
  output logic [DATA_W-1:0]   fwd_wdata_o,
  input  logic [DATA_W-1:0]   fwd_rdata_i,
  output logic                rsp_valid_o,
  output logic [DATA_W-1:0]   rsp_rdata_o,
  output logic                rsp_err_o
);

  logic sel_blk;
  logic accept;

  assign sel_blk = req_we_i ? wr_blk_i[req_part_i] : rd_blk_i[req_part_i];

  assign fwd_valid_o = req_valid_i & ~sel_blk;
  assign fwd_we_o    = req_we_i;
  assign fwd_part_o  = req_part_i;
  assign fwd_wdata_o = req_wdata_i;
  assign req_ready_o = sel_blk | fwd_ready_i;
  assign accept      = req_valid_i & req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= accept;
      rsp_err_o   <= accept & sel_blk;
      rsp_rdata_o <= (accept & ~sel_blk & ~req_we_i) ? fwd_rdata_i : '0;
    end
  end

endmodule

// File: rtl/part_lock_gate.sv
module part_lock_gate
  import plg_pkg::*;
#(
  parameter int NUM_PART = 8,
  parameter int DATA_W   = 32,
  parameter int DIGEST_W = 64,
  localparam int PIDX_W  = $clog2(NUM_PART)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_PART*DIGEST_W-1:0] digest_i,
  input  logic [NUM_PART-1:0]          sw_rd_en_i,
  input  logic                         bp_req_valid_i,
  output logic                         bp_req_ready_o,
  input  logic                         bp_req_we_i,
  input  logic [PIDX_W-1:0]            bp_req_part_i,
  input  logic [DATA_W-1:0]            bp_req_wdata_i,
  output logic                         bp_fwd_valid_o,
  input  logic                         bp_fwd_ready_i,
  output logic                         bp_fwd_we_o,
  output logic [PIDX_W-1:0]            bp_fwd_part_o,
  output logic [DATA_W-1:0]            bp_fwd_wdata_o,
  input  logic [DATA_W-1:0]            bp_fwd_rdata_i,
  output logic                         bp_rsp_valid_o,
  output logic [DATA_W-1:0]            bp_rsp_rdata_o,
  output logic                         bp_rsp_err_o,
  input  logic                         da_req_valid_i,
  output logic                         da_req_ready_o,
  input  logic                         da_req_we_i,
  input  logic [PIDX_W-1:0]            da_req_part_i,
  input  logic [DATA_W-1:0]            da_req_wdata_i,
  output logic                         da_fwd_valid_o,
  input  logic                         da_fwd_ready_i,
  output logic                         da_fwd_we_o,
  output logic [PIDX_W-1:0]            da_fwd_part_o,
  output logic [DATA_W-1:0]            da_fwd_wdata_o,
  input  logic [DATA_W-1:0]            da_fwd_rdata_i,
  output logic                         da_rsp_valid_o,
  output logic [DATA_W-1:0]            da_rsp_rdata_o,
  output logic                         da_rsp_err_o
);

  // Raw redundant lock bytes, one set per access path.
  logic [NUM_PART-1:0][7:0] bp_rd_mubi;
  logic [NUM_PART-1:0][7:0] bp_wr_mubi;
  logic [NUM_PART-1:0][7:0] da_rd_mubi;
  logic [NUM_PART-1:0][7:0] da_wr_mubi;

  // Decoded block decisions.
  logic [NUM_PART-1:0] bp_rd_blk;
  logic [NUM_PART-1:0] bp_wr_blk;
  logic [NUM_PART-1:0] da_rd_blk;
  logic [NUM_PART-1:0] da_wr_blk;

  for (genvar i = 0; i < NUM_PART; i++) begin : g_part
    logic rd_lock;
    logic wr_lock;

    lg_lock_derive #(
      .KIND     (kind_of(i, NUM_PART)),
      .DIGEST_W (DIGEST_W)
    ) u_derive (
      .digest_i  (digest_i[i*DIGEST_W +: DIGEST_W]),
      .rd_en_i   (sw_rd_en_i[i]),
      .rd_lock_o (rd_lock),
      .wr_lock_o (wr_lock)
    );

    // Separate registers per path so each set fails safe on its own.
    lg_lock_reg u_bp_lock (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rd_lock_i (rd_lock),
      .wr_lock_i (wr_lock),
      .rd_mubi_o (bp_rd_mubi[i]),
      .wr_mubi_o (bp_wr_mubi[i])
    );

    lg_lock_reg u_da_lock (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rd_lock_i (rd_lock),
      .wr_lock_i (wr_lock),
      .rd_mubi_o (da_rd_mubi[i]),
      .wr_mubi_o (da_wr_mubi[i])
    );

    assign bp_rd_blk[i] = mubi8_blocks(bp_rd_mubi[i]);
    assign bp_wr_blk[i] = mubi8_blocks(bp_wr_mubi[i]);
    assign da_rd_blk[i] = mubi8_blocks(da_rd_mubi[i]);
    assign da_wr_blk[i] = mubi8_blocks(da_wr_mubi[i]);
  end

  lg_path_gate #(
    .NUM_PART (NUM_PART),
    .DATA_W   (DATA_W)
  ) u_bp_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_blk_i    (bp_rd_blk),
    .wr_blk_i    (bp_wr_blk),
    .req_valid_i (bp_req_valid_i),
    .req_ready_o (bp_req_ready_o),
    .req_we_i    (bp_req_we_i),
    .req_part_i  (bp_req_part_i),
    .req_wdata_i (bp_req_wdata_i),
    .fwd_valid_o (bp_fwd_valid_o),
    .fwd_ready_i (bp_fwd_ready_i),
    .fwd_we_o    (bp_fwd_we_o),
    .fwd_part_o  (bp_fwd_part_o),
    .fwd_wdata_o (bp_fwd_wdata_o),
    .fwd_rdata_i (bp_fwd_rdata_i),
    .rsp_valid_o (bp_rsp_valid_o),
    .rsp_rdata_o (bp_rsp_rdata_o),
    .rsp_err_o   (bp_rsp_err_o)
  );

  lg_path_gate #(
    .NUM_PART (NUM_PART),
    .DATA_W   (DATA_W)
  ) u_da_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_blk_i    (da_rd_blk),
    .wr_blk_i    (da_wr_blk),
    .req_valid_i (da_req_valid_i),
    .req_ready_o (da_req_ready_o),
    .req_we_i    (da_req_we_i),
    .req_part_i  (da_req_part_i),
    .req_wdata_i (da_req_wdata_i),
    .fwd_valid_o (da_fwd_valid_o),
    .fwd_ready_i (da_fwd_ready_i),
    .fwd_we_o    (da_fwd_we_o),
    .fwd_part_o  (da_fwd_part_o),
    .fwd_wdata_o (da_fwd_wdata_o),
    .fwd_rdata_i (da_fwd_rdata_i),
    .rsp_valid_o (da_rsp_valid_o),
    .rsp_rdata_o (da_rsp_rdata_o),
    .rsp_err_o   (da_rsp_err_o)
  );

endmodule

// File: rtl/part_lock_gate_chk.sv
module part_lock_gate_chk #(
  parameter int NUM_PART = 8,
  parameter int DATA_W   = 32,
  localparam int PIDX_W  = $clog2(NUM_PART)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [NUM_PART-1:0][7:0] bp_rd_mubi,
  input logic [NUM_PART-1:0][7:0] bp_wr_mubi,
  input logic [NUM_PART-1:0][7:0] da_rd_mubi,
  input logic [NUM_PART-1:0][7:0] da_wr_mubi,
  input logic                     bp_req_valid_i,
  input logic                     bp_req_ready_o,
  input logic                     bp_fwd_valid_o,
  input logic                     bp_fwd_ready_i,
  input logic                     bp_fwd_we_o,
  input logic [PIDX_W-1:0]        bp_fwd_part_o,
  input logic                     bp_rsp_valid_o,
  input logic [DATA_W-1:0]        bp_rsp_rdata_o,
  input logic                     bp_rsp_err_o,
  input logic                     da_req_valid_i,
  input logic                     da_req_ready_o,
  input logic                     da_fwd_valid_o,
  input logic                     da_fwd_ready_i,
  input logic                     da_fwd_we_o,
  input logic [PIDX_W-1:0]        da_fwd_part_o,
  input logic                     da_rsp_valid_o,
  input logic [DATA_W-1:0]        da_rsp_rdata_o,
  input logic                     da_rsp_err_o
);

  // R2 R8
  bp_fwd_unlocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bp_fwd_valid_o |-> ((bp_fwd_we_o ? bp_wr_mubi[bp_fwd_part_o] : bp_rd_mubi[bp_fwd_part_o])
                        == 8'h69));

  // R2 R8
  da_fwd_unlocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    da_fwd_valid_o |-> ((da_fwd_we_o ? da_wr_mubi[da_fwd_part_o] : da_rd_mubi[da_fwd_part_o])
                        == 8'h69));

  // R11
  bp_rsp_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bp_req_valid_i && bp_req_ready_o) |=> bp_rsp_valid_o);

  // R11
  da_rsp_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (da_req_valid_i && da_req_ready_o) |=> da_rsp_valid_o);

  // R11
  bp_no_spurious_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bp_req_valid_i && bp_req_ready_o) |=> !bp_rsp_valid_o);

  // R11
  da_no_spurious_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(da_req_valid_i && da_req_ready_o) |=> !da_rsp_valid_o);

  // R9
  bp_err_zero_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bp_rsp_valid_o && bp_rsp_err_o) |-> (bp_rsp_rdata_o == '0));

  // R9
  da_err_zero_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (da_rsp_valid_o && da_rsp_err_o) |-> (da_rsp_rdata_o == '0));

  // R9 R10
  bp_stall_only_downstream_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bp_req_valid_i && !bp_req_ready_o) |-> (bp_fwd_valid_o && !bp_fwd_ready_i));

  // R9 R10
  da_stall_only_downstream_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (da_req_valid_i && !da_req_ready_o) |-> (da_fwd_valid_o && !da_fwd_ready_i));

  // R10
  bp_fwd_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bp_fwd_valid_o |-> bp_req_valid_i);

  // R10
  da_fwd_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    da_fwd_valid_o |-> da_req_valid_i);

endmodule

bind part_lock_gate part_lock_gate_chk #(
  .NUM_PART (NUM_PART),
  .DATA_W   (DATA_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .bp_rd_mubi     (bp_rd_mubi),
  .bp_wr_mubi     (bp_wr_mubi),
  .da_rd_mubi     (da_rd_mubi),
  .da_wr_mubi     (da_wr_mubi),
  .bp_req_valid_i (bp_req_valid_i),
  .bp_req_ready_o (bp_req_ready_o),
  .bp_fwd_valid_o (bp_fwd_valid_o),
  .bp_fwd_ready_i (bp_fwd_ready_i),
  .bp_fwd_we_o    (bp_fwd_we_o),
  .bp_fwd_part_o  (bp_fwd_part_o),
  .bp_rsp_valid_o (bp_rsp_valid_o),
  .bp_rsp_rdata_o (bp_rsp_rdata_o),
  .bp_rsp_err_o   (bp_rsp_err_o),
  .da_req_valid_i (da_req_valid_i),
  .da_req_ready_o (da_req_ready_o),
  .da_fwd_valid_o (da_fwd_valid_o),
  .da_fwd_ready_i (da_fwd_ready_i),
  .da_fwd_we_o    (da_fwd_we_o),
  .da_fwd_part_o  (da_fwd_part_o),
  .da_rsp_valid_o (da_rsp_valid_o),
  .da_rsp_rdata_o (da_rsp_rdata_o),
  .da_rsp_err_o   (da_rsp_err_o)
);

// File: tb/tb_part_lock_gate.sv
`timescale 1ns/1ps
module tb_part_lock_gate;

  localparam int NP = 8;
  localparam int DW = 32;
  localparam int GW = 64;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP*GW-1:0] digest = '0;
  logic [NP-1:0] rd_en = '1;

  logic          bp_req_valid = 1'b0, bp_req_we = 1'b0, bp_fwd_ready = 1'b1;
  logic [PW-1:0] bp_req_part = '0;
  logic [DW-1:0] bp_req_wdata = '0;
  logic          da_req_valid = 1'b0, da_req_we = 1'b0, da_fwd_ready = 1'b1;
  logic [PW-1:0] da_req_part = '0;
  logic [DW-1:0] da_req_wdata = '0;

  logic          bp_req_ready, bp_fwd_valid, bp_fwd_we, bp_rsp_valid, bp_rsp_err;
  logic [PW-1:0] bp_fwd_part;
  logic [DW-1:0] bp_fwd_wdata, bp_fwd_rdata, bp_rsp_rdata;
  logic          da_req_ready, da_fwd_valid, da_fwd_we, da_rsp_valid, da_rsp_err;
  logic [PW-1:0] da_fwd_part;
  logic [DW-1:0] da_fwd_wdata, da_fwd_rdata, da_rsp_rdata;

  // Storage model: read data depends on the partition.
  assign bp_fwd_rdata = 32'hB000_0000 | 32'(bp_fwd_part);
  assign da_fwd_rdata = 32'hD000_0000 | 32'(da_fwd_part);

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] frc_val;

  always #2.5 clk = ~clk;

  part_lock_gate dut (
    .clk_i(clk), .rst_ni(rst_n), .digest_i(digest), .sw_rd_en_i(rd_en),
    .bp_req_valid_i(bp_req_valid), .bp_req_ready_o(bp_req_ready), .bp_req_we_i(bp_req_we),
    .bp_req_part_i(bp_req_part), .bp_req_wdata_i(bp_req_wdata),
    .bp_fwd_valid_o(bp_fwd_valid), .bp_fwd_ready_i(bp_fwd_ready), .bp_fwd_we_o(bp_fwd_we),
    .bp_fwd_part_o(bp_fwd_part), .bp_fwd_wdata_o(bp_fwd_wdata), .bp_fwd_rdata_i(bp_fwd_rdata),
    .bp_rsp_valid_o(bp_rsp_valid), .bp_rsp_rdata_o(bp_rsp_rdata), .bp_rsp_err_o(bp_rsp_err),
    .da_req_valid_i(da_req_valid), .da_req_ready_o(da_req_ready), .da_req_we_i(da_req_we),
    .da_req_part_i(da_req_part), .da_req_wdata_i(da_req_wdata),
    .da_fwd_valid_o(da_fwd_valid), .da_fwd_ready_i(da_fwd_ready), .da_fwd_we_o(da_fwd_we),
    .da_fwd_part_o(da_fwd_part), .da_fwd_wdata_o(da_fwd_wdata), .da_fwd_rdata_i(da_fwd_rdata),
    .da_rsp_valid_o(da_rsp_valid), .da_rsp_rdata_o(da_rsp_rdata), .da_rsp_err_o(da_rsp_err)
  );

  // Vector: {digest mask[7:0], rd_en[7:0], path(0=bp,1=da), we, part[2:0], exp_blk, req[3:0]}
  localparam int NVEC = 16;
  localparam logic [25:0] VEC [NVEC] = '{
    {8'h00, 8'hFF, 1'b0, 1'b0, 3'd0, 1'b0, 4'd1},  // R1 unlocked read
    {8'h00, 8'hFF, 1'b0, 1'b1, 3'd0, 1'b0, 4'd1},  // R1 unlocked write
    {8'h01, 8'hFF, 1'b0, 1'b1, 3'd0, 1'b1, 4'd3},  // R3 low half nonzero
    {8'h02, 8'hFF, 1'b1, 1'b1, 3'd1, 1'b1, 4'd3},  // R3 high half nonzero
    {8'h02, 8'hFF, 1'b0, 1'b0, 3'd1, 1'b0, 4'd3},  // R3 digest does not read-lock sw part
    {8'h00, 8'hFB, 1'b0, 1'b0, 3'd2, 1'b1, 4'd4},  // R4 read-enable cleared
    {8'h00, 8'hFB, 1'b1, 1'b0, 3'd2, 1'b1, 4'd4},  // R4 direct path too
    {8'h00, 8'hFB, 1'b0, 1'b1, 3'd2, 1'b0, 4'd4},  // R4 write unaffected
    {8'h08, 8'hF7, 1'b0, 1'b0, 3'd3, 1'b0, 4'd5},  // R5 hw never read-locked
    {8'h08, 8'hF7, 1'b1, 1'b1, 3'd3, 1'b1, 4'd5},  // R5 hw write lock
    {8'h10, 8'hFF, 1'b0, 1'b0, 3'd4, 1'b1, 4'd6},  // R6 secret read
    {8'h10, 8'hFF, 1'b1, 1'b1, 3'd4, 1'b1, 4'd6},  // R6 secret write
    {8'h40, 8'hFF, 1'b1, 1'b0, 3'd6, 1'b1, 4'd6},  // R6 secret2 read
    {8'h40, 8'hFF, 1'b0, 1'b0, 3'd5, 1'b0, 4'd6},  // R6 other secret open
    {8'hFF, 8'h00, 1'b0, 1'b0, 3'd7, 1'b0, 4'd7},  // R7 life cycle read
    {8'hFF, 8'h00, 1'b1, 1'b1, 3'd7, 1'b0, 4'd7}   // R7 life cycle write
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NP*GW-1:0] mk_digest(input logic [7:0] mask);
    logic [NP*GW-1:0] d = '0;
    for (int i = 0; i < NP; i++) begin
      if (mask[i]) begin
        if (i % 2 == 0) d[i*GW +: GW] = 64'h0000_0000_0000_0001;
        else            d[i*GW +: GW] = 64'h8000_0000_0000_0000;
      end
    end
    return d;
  endfunction

  // One request; checks forwarding, ready and the next-cycle response.
  task automatic run_req(input bit path, input bit we, input logic [2:0] part,
                         input bit exp_blk, input string req);
    logic [31:0] exp_data;
    @(negedge clk);
    if (!path) begin
      bp_req_valid = 1'b1; bp_req_we = we; bp_req_part = part; bp_req_wdata = 32'h1234_5678;
    end else begin
      da_req_valid = 1'b1; da_req_we = we; da_req_part = part; da_req_wdata = 32'h8765_4321;
    end
    #1;
    chk((path ? da_fwd_valid : bp_fwd_valid) == !exp_blk, req,
        32'(path ? da_fwd_valid : bp_fwd_valid), 32'(!exp_blk));
    chk((path ? da_req_ready : bp_req_ready) == 1'b1, req,
        32'(path ? da_req_ready : bp_req_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    bp_req_valid = 1'b0; da_req_valid = 1'b0;
    exp_data = (exp_blk || we) ? 32'h0 : ((path ? 32'hD000_0000 : 32'hB000_0000) | 32'(part));
    chk((path ? da_rsp_valid : bp_rsp_valid) == 1'b1, {req, " R11"},
        32'(path ? da_rsp_valid : bp_rsp_valid), 32'd1);
    chk((path ? da_rsp_err : bp_rsp_err) == exp_blk, {req, " R9/R10 err"},
        32'(path ? da_rsp_err : bp_rsp_err), 32'(exp_blk));
    chk((path ? da_rsp_rdata : bp_rsp_rdata) == exp_data, {req, " data"},
        path ? da_rsp_rdata : bp_rsp_rdata, exp_data);
  endtask

  task automatic set_locks(input logic [7:0] mask, input logic [7:0] en);
    @(negedge clk);
    digest = mk_digest(mask);
    rd_en = en;
    @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R11 reset state: no responses while in reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(bp_rsp_valid == 1'b0 && da_rsp_valid == 1'b0, "R11 reset rsp",
        {30'd0, bp_rsp_valid, da_rsp_valid}, 32'd0);
    rst_n = 1'b1;
    // R1 reset pattern unlocks: request right after reset passes
    run_req(1'b0, 1'b0, 3'd4, 1'b0, "R1 after reset");

    for (int v = 0; v < NVEC; v++) begin
      logic [25:0] e;
      string tag;
      e = VEC[v];
      tag = $sformatf("R%0d vec%0d", e[3:0], v);
      set_locks(e[25:18], e[17:10]);
      run_req(e[9], e[8], e[7:5], e[4], tag);
    end

    // R3 timing: lock in effect on the first edge after digest change
    set_locks(8'h00, 8'hFF);
    @(negedge clk);
    digest = mk_digest(8'h20);
    bp_req_valid = 1'b1; bp_req_we = 1'b1; bp_req_part = 3'd5;
    #1;
    chk(bp_fwd_valid == 1'b1, "R3 before edge", 32'(bp_fwd_valid), 32'd1);
    bp_fwd_ready = 1'b0;
    @(posedge clk);
    #1;
    chk(bp_fwd_valid == 1'b0 && bp_req_ready == 1'b1, "R3 after edge",
        {30'd0, bp_fwd_valid, bp_req_ready}, 32'd1);
    @(negedge clk);
    bp_req_valid = 1'b0; bp_fwd_ready = 1'b1;

    // R10 back-pressure on an allowed request, R9 blocked ignores it
    set_locks(8'h00, 8'hFF);
    @(negedge clk);
    bp_fwd_ready = 1'b0;
    bp_req_valid = 1'b1; bp_req_we = 1'b0; bp_req_part = 3'd0;
    #1;
    chk(bp_req_ready == 1'b0 && bp_fwd_valid == 1'b1, "R10 stall",
        {30'd0, bp_req_ready, bp_fwd_valid}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    chk(bp_rsp_valid == 1'b0, "R11 no rsp while stalled", 32'(bp_rsp_valid), 32'd0);
    bp_req_valid = 1'b0;
    set_locks(8'h00, 8'hFE);
    @(negedge clk);
    bp_req_valid = 1'b1;
    #1;
    chk(bp_req_ready == 1'b1 && bp_fwd_valid == 1'b0, "R9 blocked despite stall",
        {30'd0, bp_req_ready, bp_fwd_valid}, 32'd2);
    @(posedge clk);
    @(negedge clk);
    bp_req_valid = 1'b0; bp_fwd_ready = 1'b1;
    chk(bp_rsp_valid && bp_rsp_err && bp_rsp_rdata == 0, "R9 blocked rsp",
        {bp_rsp_rdata[29:0], bp_rsp_valid, bp_rsp_err}, 32'd3);

    // R2 R8: corrupt single lock bytes in one set only
    set_locks(8'h00, 8'hFF);
    for (int k = 0; k < 6; k++) begin
      frc_val = 8'($urandom);
      if (frc_val == 8'h69 || frc_val == 8'h96) frc_val = frc_val ^ 8'h01;
      if (k == 0) frc_val = 8'h00;
      if (k == 1) frc_val = 8'h68;
      force dut.g_part[2].u_bp_lock.rd_q = frc_val;
      force dut.g_part[4].u_da_lock.wr_q = frc_val;
      run_req(1'b0, 1'b0, 3'd2, 1'b1, "R2 forced bp read lock");
      run_req(1'b1, 1'b0, 3'd2, 1'b0, "R8 da read unaffected");
      run_req(1'b1, 1'b1, 3'd4, 1'b1, "R2 forced da write lock");
      run_req(1'b0, 1'b1, 3'd4, 1'b0, "R8 bp write unaffected");
      release dut.g_part[2].u_bp_lock.rd_q;
      release dut.g_part[4].u_da_lock.wr_q;
      @(posedge clk);
      // R1 recovery after release
      run_req(1'b0, 1'b0, 3'd2, 1'b0, "R1 bp read restored");
      run_req(1'b1, 1'b1, 3'd4, 1'b0, "R1 da write restored");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule